// File: doc/BRIEF.md
# Exception Entry Unit

This block turns a fault reported by the pipeline into an exception entry for a small RISC control coprocessor. Each accepted request names a fault kind, says whether the access was a store, and carries the faulting PC, virtual address, address-space ID, virtual page number and coprocessor number. From the request and the current control state the unit works out a 5-bit exception code and a handler address. It updates the control registers, and one cycle later it sends the fetch stage a redirect pulse with that address.

The handler address depends on three control bits. A boot bit in status chooses between a fixed boot base and a programmable exception base. An interrupt-vector bit in cause moves interrupts to a dedicated offset. The exception-level bit in status moves a TLB refill off its fast slot. TLB faults also load the translation registers: the page number is split between an upper field and a two-bit low field. Status, cause and the exception base can be written through a small register port. All seven registers can be read through it.

Top module: `exc_entry_unit`

## Requirements
- R1: `req_type` encoding and resulting code: 0 interrupt→0, 1 TLB modified→1, 2 TLB refill and 3 TLB invalid→3 if `req_store` else 2, 4 address error→5 if store else 4, 5 instruction bus→6, 6 data bus→7, 7 syscall→8, 8 breakpoint→9, 9 reserved instruction→10, 10 coprocessor unusable→11, 11 overflow→12, 12 trap→13, 13 coprocessor-2→18, 14 media→22, 15 watch→23, 16 machine check→24, 17 thread→25, 18 cache error→30; any other value→10.
- R2: The vector base is 0xBFC00200 when status bit 22 is 1. Otherwise it is the exception base register. The redirect address is base plus offset.
- R3: The offset is 0x200 for an interrupt when cause bit 23 is 1, and 0x180 when it is 0. A TLB refill uses 0x000 when status bit 1 is 0, and 0x180 when it is 1. Every other fault, TLB invalid included, uses 0x180.
- R4: `redirect_valid` pulses for exactly one cycle, in the cycle after the request is accepted. `busy` is high in that cycle, and a request presented while `busy` is high is ignored.
- R5: Entry writes the code into cause bits [6:2]. A coprocessor-unusable fault also writes `req_cpid` into cause bits [29:28]. All other cause bits keep their values.
- R6: Entry sets status bit 1. EPC takes `req_pc` only if status bit 1 was 0 before the entry.
- R7: Address-error and TLB faults (types 1 to 4) load `req_vaddr` into the bad-address register. Other faults leave it unchanged.
- R8: On a TLB fault (types 1 to 3), entry-high becomes {vpn[20:2] at [31:13], vpn[1:0] at [12:11], zero at [10:8], asid at [7:0]}. The context register becomes vpn[20:2] at [22:4], with zero elsewhere.
- R9: `reg_sel` selects 0 status, 1 cause, 2 exception base, 3 EPC, 4 bad address, 5 entry-high, 6 context; 7 reads zero. Only selects 0 to 2 are writable. Exception base bits [11:0] always read zero. A write in the same cycle as an accepted request is dropped.
- R10: After reset, status is 0x00400000, the exception base is 0x80000000, and all other registers and `redirect_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fault request present |
| req_type | input | 5 | Fault kind |
| req_store | input | 1 | Faulting access was a store |
| req_pc | input | 32 | PC of the faulting instruction |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | Address-space ID |
| req_vpn | input | 21 | Faulting virtual page number |
| req_cpid | input | 2 | Unusable coprocessor number |
| busy | output | 1 | Request not accepted this cycle |
| redirect_valid | output | 1 | Redirect pulse to fetch |
| redirect_pc | output | 32 | Handler address |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_sel | input | 3 | Register port select |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, an 8-bit ASID, a 21-bit page number and the OR-merge variant of the programmable-base path. With these values, every one of the nineteen fault kinds is driven under all sixteen combinations of the store flag, the boot bit, the interrupt-vector bit and the exception-level bit. The page-number split and the ASID placement are checked at their real bit positions, and the aligned exception base lets the OR merge be compared against an arithmetic sum in the model.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [4:0] {
      FT_INTR = 5'd0, FT_TLB_MOD = 5'd1, FT_TLB_REFILL = 5'd2, FT_TLB_INVAL = 5'd3,
      FT_ADDR_ERR = 5'd4, FT_IBUS = 5'd5, FT_DBUS = 5'd6, FT_SYSCALL = 5'd7,
      FT_BREAK = 5'd8, FT_RESV = 5'd9, FT_CP_UNUSE = 5'd10, FT_OVF = 5'd11,
      FT_TRAP = 5'd12, FT_CP2 = 5'd13, FT_MEDIA = 5'd14, FT_WATCH = 5'd15,
      FT_MCHECK = 5'd16, FT_THREAD = 5'd17, FT_CACHE = 5'd18
   } fault_t;

   typedef enum logic [2:0] {
      RS_STATUS = 3'd0, RS_CAUSE = 3'd1, RS_EBASE = 3'd2, RS_EPC = 3'd3,
      RS_BADADDR = 3'd4, RS_ENTRYHI = 3'd5, RS_CONTEXT = 3'd6, RS_NONE = 3'd7
   } reg_sel_t;

   localparam int OFF_W       = 12;
   localparam int ST_LVL_BIT  = 1;
   localparam int ST_BOOT_BIT = 22;
   localparam int CA_VEC_BIT  = 23;
   localparam int CA_CODE_LO  = 2;
   localparam int CA_CP_LO    = 28;
   localparam int CTX_LO      = 4;

   localparam logic [OFF_W-1:0] OFF_REFILL = 12'h000;
   localparam logic [OFF_W-1:0] OFF_GEN    = 12'h180;
   localparam logic [OFF_W-1:0] OFF_IRQ    = 12'h200;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_pkg::*;
(
   input  logic [4:0]       ftype,
   input  logic             store,
   input  logic             irq_vec,
   input  logic             in_exc,
   output logic [4:0]       code,
   output logic [OFF_W-1:0] offset,
   output logic             tlb_fault,
   output logic             load_bad,
   output logic             load_cp
);
   always_comb begin
      code      = 5'd10;
      offset    = OFF_GEN;
      tlb_fault = 1'b0;
      load_bad  = 1'b0;
      load_cp   = 1'b0;
      case (fault_t'(ftype))
         FT_INTR:       begin code = 5'd0; offset = irq_vec ? OFF_IRQ : OFF_GEN; end
         FT_TLB_MOD:    begin code = 5'd1; tlb_fault = 1'b1; load_bad = 1'b1; end
         FT_TLB_REFILL: begin
            code = store ? 5'd3 : 5'd2;
            offset = in_exc ? OFF_GEN : OFF_REFILL;
            tlb_fault = 1'b1; load_bad = 1'b1;
         end
         FT_TLB_INVAL:  begin code = store ? 5'd3 : 5'd2; tlb_fault = 1'b1; load_bad = 1'b1; end
         FT_ADDR_ERR:   begin code = store ? 5'd5 : 5'd4; load_bad = 1'b1; end
         FT_IBUS:       code = 5'd6;
         FT_DBUS:       code = 5'd7;
         FT_SYSCALL:    code = 5'd8;
         FT_BREAK:      code = 5'd9;
         FT_RESV:       code = 5'd10;
         FT_CP_UNUSE:   begin code = 5'd11; load_cp = 1'b1; end
         FT_OVF:        code = 5'd12;
         FT_TRAP:       code = 5'd13;
         FT_CP2:        code = 5'd18;
         FT_MEDIA:      code = 5'd22;
         FT_WATCH:      code = 5'd23;
         FT_MCHECK:     code = 5'd24;
         FT_THREAD:     code = 5'd25;
         FT_CACHE:      code = 5'd30;
         default:       code = 5'd10;
      endcase
   end

   // R3: the fast refill slot is used only outside exception level
   always_comb begin
      if (offset == OFF_REFILL)
         p_refill_slot_r3: assert (tlb_fault && !in_exc && code != 5'd1)
            else $error("refill offset chosen outside a first-level refill");
   end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
   import exc_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC0_0200,
   parameter bit              OR_MERGE = 1'b1
) (
   input  logic              boot,
   input  logic [ADDR_W-1:0] ebase,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] vec
);
   localparam int PAD_W = ADDR_W - OFF_W;
   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] prog_vec;

   assign off_ext = {{PAD_W{1'b0}}, offset};

   generate
      if (OR_MERGE) begin : g_or
         // base is 4 KiB aligned, so OR equals the sum
         assign prog_vec = ebase | off_ext;
      end else begin : g_add
         assign prog_vec = ebase + off_ext;
      end
   endgenerate

   assign vec = boot ? (BOOT_BASE + off_ext) : prog_vec;
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                ASID_W    = 8,
   parameter int                VPN_W     = 21,
   parameter int                CPID_W    = 2,
   parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hBFC0_0200,
   parameter logic [ADDR_W-1:0] EBASE_RST = 32'h8000_0000,
   parameter bit                OR_MERGE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [4:0]        req_type,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_pc,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [ASID_W-1:0] req_asid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [CPID_W-1:0] req_cpid,
   output logic              busy,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata
);
   localparam int VPN2_W   = VPN_W - 2;
   localparam int EHX_LO   = ADDR_W - VPN_W;
   localparam logic [ADDR_W-1:0] STATUS_RST = ADDR_W'(1) << ST_BOOT_BIT;
   localparam logic [ADDR_W-1:0] EBASE_MSK  = ~ADDR_W'((1 << OFF_W) - 1);

   initial begin
      a_vpn_w: assert (VPN_W > 2) else $error("VPN_W too small");
      a_asid_fit: assert (ASID_W <= EHX_LO) else $error("ASID overlaps page field");
      a_ctx_fit: assert (CTX_LO + VPN2_W <= ADDR_W) else $error("context field too wide");
      a_cp_fit: assert (CA_CP_LO + CPID_W <= ADDR_W) else $error("CE field too wide");
      a_ebase_al: assert ((EBASE_RST & ~EBASE_MSK) == '0) else $error("EBASE_RST unaligned");
   end

   logic [ADDR_W-1:0] status_q, cause_q, ebase_q, epc_q, bad_q, eh_q, ctx_q;
   logic              redir_q;
   logic [ADDR_W-1:0] redir_pc_q;

   logic              accept;
   logic [4:0]        code;
   logic [OFF_W-1:0]  offset;
   logic              tlb_fault, load_bad, load_cp;
   logic [ADDR_W-1:0] vec, eh_new, ctx_new;

   assign accept = req_valid && !redir_q;

   exc_classify u_classify (
      .ftype     (req_type),
      .store     (req_store),
      .irq_vec   (cause_q[CA_VEC_BIT]),
      .in_exc    (status_q[ST_LVL_BIT]),
      .code      (code),
      .offset    (offset),
      .tlb_fault (tlb_fault),
      .load_bad  (load_bad),
      .load_cp   (load_cp)
   );

   exc_vector #(
      .ADDR_W    (ADDR_W),
      .BOOT_BASE (BOOT_BASE),
      .OR_MERGE  (OR_MERGE)
   ) u_vector (
      .boot   (status_q[ST_BOOT_BIT]),
      .ebase  (ebase_q),
      .offset (offset),
      .vec    (vec)
   );

   always_comb begin
      eh_new = '0;
      eh_new[ASID_W-1:0]           = req_asid;
      eh_new[EHX_LO +: 2]          = req_vpn[1:0];
      eh_new[ADDR_W-1 -: VPN2_W]   = req_vpn[VPN_W-1:2];
      ctx_new = '0;
      ctx_new[CTX_LO +: VPN2_W]    = req_vpn[VPN_W-1:2];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q   <= STATUS_RST;
         cause_q    <= '0;
         ebase_q    <= EBASE_RST;
         epc_q      <= '0;
         bad_q      <= '0;
         eh_q       <= '0;
         ctx_q      <= '0;
         redir_q    <= 1'b0;
         redir_pc_q <= '0;
      end else begin
         redir_q <= accept;
         if (accept) begin
            redir_pc_q <= vec;
            status_q[ST_LVL_BIT] <= 1'b1;
            if (!status_q[ST_LVL_BIT]) epc_q <= req_pc;
            cause_q[CA_CODE_LO +: 5] <= code;
            if (load_cp) cause_q[CA_CP_LO +: CPID_W] <= req_cpid;
            if (load_bad) bad_q <= req_vaddr;
            if (tlb_fault) begin
               eh_q  <= eh_new;
               ctx_q <= ctx_new;
            end
         end else if (reg_wr_en) begin
            case (reg_sel_t'(reg_sel))
               RS_STATUS: status_q <= reg_wdata;
               RS_CAUSE:  cause_q  <= reg_wdata;
               RS_EBASE:  ebase_q  <= reg_wdata & EBASE_MSK;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_sel_t'(reg_sel))
         RS_STATUS:  reg_rdata = status_q;
         RS_CAUSE:   reg_rdata = cause_q;
         RS_EBASE:   reg_rdata = ebase_q;
         RS_EPC:     reg_rdata = epc_q;
         RS_BADADDR: reg_rdata = bad_q;
         RS_ENTRYHI: reg_rdata = eh_q;
         RS_CONTEXT: reg_rdata = ctx_q;
         default:    reg_rdata = '0;
      endcase
   end

   assign busy           = redir_q;
   assign redirect_valid = redir_q;
   assign redirect_pc    = redir_pc_q;

   p_pulse_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !redirect_valid);
   p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> status_q[ST_LVL_BIT]);
   p_epc_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept && status_q[ST_LVL_BIT] |=> $stable(epc_q));
   p_bad_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && load_bad |=> bad_q == $past(req_vaddr));
   p_boot_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept && status_q[ST_BOOT_BIT] |=> redirect_pc[ADDR_W-1:OFF_W] == BOOT_BASE[ADDR_W-1:OFF_W]);
   p_code_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> cause_q[CA_CODE_LO +: 5] == $past(code));
endmodule

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_type = '0;
   logic        req_store = 1'b0;
   logic [31:0] req_pc = '0, req_vaddr = '0;
   logic [7:0]  req_asid = '0;
   logic [20:0] req_vpn = '0;
   logic [1:0]  req_cpid = '0;
   logic        busy, redirect_valid;
   logic [31:0] redirect_pc;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] exp_q[$];
   logic [31:0] m_status, m_cause, m_ebase, m_epc, m_bad, m_eh, m_ctx;

   always #4 clk = ~clk;

   exc_entry_unit u_exc_entry_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
      .req_store(req_store), .req_pc(req_pc), .req_vaddr(req_vaddr),
      .req_asid(req_asid), .req_vpn(req_vpn), .req_cpid(req_cpid),
      .busy(busy), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a redirect appears
   always @(negedge clk) begin
      if (rst_n && redirect_valid) begin
         if (exp_q.size() == 0) cmp("R4 unexpected redirect", redirect_pc, 32'hxxxx_xxxx);
         else cmp("R1/R2/R3 redirect vector", redirect_pc, exp_q.pop_front());
      end
   end

   function automatic logic [4:0] ref_code(input int t, input bit st);
      case (t)
         0: return 0;   1: return 1;   2, 3: return st ? 3 : 2;
         4: return st ? 5 : 4;         5: return 6;   6: return 7;
         7: return 8;   8: return 9;   9: return 10;  10: return 11;
         11: return 12; 12: return 13; 13: return 18; 14: return 22;
         15: return 23; 16: return 24; 17: return 25; 18: return 30;
         default: return 10;
      endcase
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
      case (sel)
         0: m_status = d;
         1: m_cause = d;
         2: m_ebase = d & 32'hFFFF_F000;
         default: ;
      endcase
   endtask

   task automatic rd_chk(input logic [2:0] sel, input logic [31:0] exp, input string req);
      reg_sel = sel;
      #1;
      cmp(req, reg_rdata, exp);
   endtask

   // driver: model the fault, push the expected vector, present the request
   task automatic fault(input int t, input bit st, input logic [31:0] pc,
                        input logic [31:0] va, input logic [7:0] asid,
                        input logic [20:0] vpn, input logic [1:0] cp);
      logic [11:0] off;
      logic [31:0] base;
      bit exl;
      exl = m_status[1];
      off = 12'h180;
      if (t == 0 && m_cause[23]) off = 12'h200;
      if (t == 2 && !exl) off = 12'h000;
      base = m_status[22] ? 32'hBFC0_0200 : m_ebase;
      exp_q.push_back(base + {20'd0, off});
      if (!exl) m_epc = pc;
      m_status[1] = 1'b1;
      m_cause[6:2] = ref_code(t, st);
      if (t == 10) m_cause[29:28] = cp;
      if (t >= 1 && t <= 4) m_bad = va;
      if (t >= 1 && t <= 3) begin
         m_eh = {vpn[20:2], vpn[1:0], 3'b000, asid};
         m_ctx = {9'd0, vpn[20:2], 4'd0};
      end
      @(negedge clk);
      req_valid = 1'b1; req_type = 5'(t); req_store = st; req_pc = pc;
      req_vaddr = va; req_asid = asid; req_vpn = vpn; req_cpid = cp;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset values
      rd_chk(0, 32'h0040_0000, "R10 status reset");
      rd_chk(1, 32'h0, "R10 cause reset");
      rd_chk(2, 32'h8000_0000, "R10 ebase reset");
      rd_chk(3, 32'h0, "R10 epc reset");
      rd_chk(4, 32'h0, "R10 badaddr reset");
      rd_chk(5, 32'h0, "R10 entryhi reset");
      rd_chk(6, 32'h0, "R10 context reset");
      cmp("R10 redirect idle", {31'd0, redirect_valid}, 32'd0);
      m_status = 32'h0040_0000; m_cause = 0; m_ebase = 32'h8000_0000;
      m_epc = 0; m_bad = 0; m_eh = 0; m_ctx = 0;

      // R9 ebase alignment, select 7, read-only EPC
      wr(2, 32'h8003_5ABC);
      rd_chk(2, 32'h8003_5000, "R9 ebase low bits zero");
      rd_chk(7, 32'h0, "R9 select 7 reads zero");
      wr(3, 32'h1234_5678);
      rd_chk(3, 32'h0, "R9 epc not writable");

      for (int t = 0; t < 19; t++) begin
         for (int combo = 0; combo < 16; combo++) begin
            bit st, bev, iv, exl;
            logic [31:0] pc, va;
            logic [20:0] vpn;
            st = combo[0]; bev = combo[1]; iv = combo[2]; exl = combo[3];
            pc  = 32'h0040_0000 + 32'(t * 64 + combo * 4);
            va  = 32'h7A00_0000 ^ 32'(t * 4099 + combo * 17);
            vpn = 21'h1A5C3 ^ 21'(t * 131 + combo * 7);
            wr(0, (32'(bev) << 22) | (32'(exl) << 1));
            wr(1, (32'(iv) << 23) | 32'h0000_0300);
            fault(t, st, pc, va, 8'(8'h40 + t), vpn, 2'(combo));
            rd_chk(0, m_status, "R6 status level bit");
            rd_chk(1, m_cause, "R5 cause code and CE");
            rd_chk(3, m_epc, "R6 epc capture");
            rd_chk(4, m_bad, "R7 bad address");
            rd_chk(5, m_eh, "R8 entry-high split");
            rd_chk(6, m_ctx, "R8 context field");
         end
      end

      // R4: request while busy is ignored
      wr(0, 32'h0);
      wr(1, 32'h0);
      exp_q.push_back(m_ebase + 32'h180);
      @(negedge clk);
      req_valid = 1'b1; req_type = 5'd7; req_pc = 32'h0000_1000;
      @(negedge clk);
      cmp("R4 busy during redirect", {31'd0, busy}, 32'd1);
      req_type = 5'd12; req_pc = 32'h0000_2000;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rd_chk(1, 32'd8 << 2, "R4 busy request ignored (code)");
      rd_chk(3, 32'h0000_1000, "R4 epc from first request");
      cmp("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);

      // R9: write dropped in the cycle a request is accepted
      m_status[1] = 1'b1;
      exp_q.push_back(m_ebase + 32'h180);
      @(negedge clk);
      req_valid = 1'b1; req_type = 5'd8;
      reg_wr_en = 1'b1; reg_sel = 3'd2; reg_wdata = 32'h9000_0000;
      @(negedge clk);
      req_valid = 1'b0; reg_wr_en = 1'b0;
      @(negedge clk);
      rd_chk(2, m_ebase, "R9 write dropped on accept");
      rd_chk(1, 32'd9 << 2, "R1 breakpoint code");
      finish_run();
   end
endmodule